// File: doc/BRIEF.md
# Operator Run-Rate Clock Enable Selector

This block produces the clock enable that advances a small processor, so that an operator can drive it from push buttons on a board. Three active-low keys feed it: a step key, a slow-run key and a turbo key. Holding the slow-run key alone runs the processor at a heavily divided board-clock rate. Holding the slow-run and turbo keys together runs it at a much faster automatic rate. With neither held, each press of the step key advances the processor by exactly one step. The operator may move between these modes at any moment.

Every key is first brought into the board-clock domain by a two-flop synchroniser. It then passes a debouncer that accepts a new level only after it has held for a programmable number of cycles. The active mode is decoded from the debounced levels. Turbo has priority over slow-only, and slow-only has priority over stepping. The two automatic rates come from one divider that restarts whenever the mode changes, so a switch never yields a shortened or doubled pulse.

The output is a registered enable, one board clock wide, and the processor's registers are gated with it. No derived clock is produced.

Top module: `run_rate_select`

## Requirements
- R1: A synchronous active-high reset clears the enable, treats all keys as released (step mode), and keeps the enable low on the first cycle after reset.
- R2: The enable `cpu_ce` is never high for two consecutive board clocks.
- R3: A key level is accepted only after the synchronised key has held its new value for DEB_CNT consecutive cycles. A bounce shorter than DEB_CNT cycles produces no effect.
- R4: In step mode each accepted press (high-to-low on `step_key_n`) yields exactly one enable pulse, seen 3+DEB_CNT clocks after the key input changes. Holding or releasing the key yields none.
- R5: With only the slow-run key held, pulses recur every SLOW_TC clocks. The first pulse comes 3+DEB_CNT+SLOW_TC clocks after the key input changes.
- R6: With the slow-run and turbo keys both held, pulses recur every FAST_TC clocks. The first pulse comes 3+DEB_CNT+FAST_TC clocks after the keys change.
- R7: The turbo key held without the slow-run key leaves the block in step mode. It gives no automatic pulses, and step presses still work.
- R8: While an automatic mode is active, step-key presses are ignored and the pulse spacing is unchanged.
- R9: On any mode change the divider restarts. There is no pulse in the cycle after the change, and the first pulse of the new automatic mode comes one full terminal count after the change.
- R10: Releasing the automatic keys returns to step mode. After the change takes effect, no pulse appears without a step press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous reset, active high |
| step_key_n | input | 1 | Single-step key, active low |
| slow_key_n | input | 1 | Slow automatic run key, active low |
| fast_key_n | input | 1 | Turbo key, active low; acts only together with the slow key |
| cpu_ce | output | 1 | One-clock processor enable pulse |

## Verification
A key change driven between edges reaches the debounced level after 2+DEB_CNT edges and reaches the active mode one edge later. A step pulse therefore appears 3+DEB_CNT edges after the change. An automatic pulse appears 3+DEB_CNT+TC edges after it. The bench drives keys on falling edges and samples `cpu_ce` on falling edges, numbering each sample by the rising edges counted since the stimulus. It compares those indices with the ones computed from DEB_CNT, SLOW_TC and FAST_TC. For mode switches, only pulses after the change index 2+DEB_CNT are judged, because pulses from the old mode may still fall before it.

// File: rtl/run_rate_pkg.sv
package run_rate_pkg;
  typedef enum logic [1:0] {
    MODE_STEP = 2'd0,
    MODE_SLOW = 2'd1,
    MODE_FAST = 2'd2
  } run_mode_e;

  localparam int NUM_KEYS = 3;
  localparam int KEY_STEP = 0;
  localparam int KEY_SLOW = 1;
  localparam int KEY_FAST = 2;
endpackage

// File: rtl/key_conditioner.sv
module key_conditioner #(
  parameter int DEB_CNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic key_n,
  output logic pressed
);
  localparam int CW = (DEB_CNT < 2) ? 1 : $clog2(DEB_CNT);
  localparam logic [CW-1:0] LAST = CW'(DEB_CNT - 1);

  logic          meta_q, sync_q;
  logic          level_q;
  logic [CW-1:0] hold_q;

  // two-flop synchroniser, released level = 1
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= key_n;
      sync_q <= meta_q;
    end
  end

  // accept the new level after DEB_CNT consecutive cycles of disagreement
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      hold_q  <= '0;
    end else if (sync_q == level_q) begin
      hold_q  <= '0;
    end else if (hold_q == LAST) begin
      level_q <= sync_q;
      hold_q  <= '0;
    end else begin
      hold_q  <= hold_q + 1'b1;
    end
  end

  assign pressed = ~level_q;
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import run_rate_pkg::*;
#(
  parameter int SLOW_TC = 1000,
  parameter int FAST_TC = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  run_mode_e mode,
  output logic      settled,
  output logic      tick
);
  localparam int MAX_TC = (SLOW_TC > FAST_TC) ? SLOW_TC : FAST_TC;
  localparam int CW     = $clog2(MAX_TC);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TC - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TC - 1);

  run_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          auto_run;

  assign settled = (mode == mode_q);

  always_comb begin
    case (mode_q)
      MODE_SLOW: begin last = SLOW_LAST; auto_run = 1'b1; end
      MODE_FAST: begin last = FAST_LAST; auto_run = 1'b1; end
      default:   begin last = '0;        auto_run = 1'b0; end
    endcase
  end

  assign tick = settled && auto_run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STEP;
      cnt_q  <= '0;
    end else if (!settled) begin
      mode_q <= mode;
      cnt_q  <= '0;
    end else if (!auto_run || tick) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/run_rate_select.sv
module run_rate_select
  import run_rate_pkg::*;
#(
  parameter int DEB_CNT = 500000,
  parameter int SLOW_TC = 25000000,
  parameter int FAST_TC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_key_n,
  input  logic slow_key_n,
  input  logic fast_key_n,
  output logic cpu_ce
);
  logic [NUM_KEYS-1:0] keys_n;
  logic [NUM_KEYS-1:0] keys_dn;
  logic                step_dn, slow_dn, fast_dn;
  logic                step_dn_q;
  logic                settled, tick;
  run_mode_e           cur_mode;

  assign keys_n[KEY_STEP] = step_key_n;
  assign keys_n[KEY_SLOW] = slow_key_n;
  assign keys_n[KEY_FAST] = fast_key_n;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_conditioner #(.DEB_CNT(DEB_CNT)) u_cond (
      .clk     (clk),
      .rst     (rst),
      .key_n   (keys_n[k]),
      .pressed (keys_dn[k])
    );
  end

  assign step_dn = keys_dn[KEY_STEP];
  assign slow_dn = keys_dn[KEY_SLOW];
  assign fast_dn = keys_dn[KEY_FAST];

  // priority: slow+turbo, then slow, then step
  always_comb begin
    if (slow_dn && fast_dn)  cur_mode = MODE_FAST;
    else if (slow_dn)        cur_mode = MODE_SLOW;
    else                     cur_mode = MODE_STEP;
  end

  rate_divider #(.SLOW_TC(SLOW_TC), .FAST_TC(FAST_TC)) u_div (
    .clk     (clk),
    .rst     (rst),
    .mode    (cur_mode),
    .settled (settled),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_dn_q <= 1'b0;
      cpu_ce    <= 1'b0;
    end else begin
      step_dn_q <= step_dn;
      cpu_ce    <= tick ||
                   (settled && cur_mode == MODE_STEP && step_dn && !step_dn_q);
    end
  end
endmodule

// File: rtl/run_rate_select_chk.sv
module run_rate_select_chk
  import run_rate_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      cpu_ce,
  input logic      step_dn,
  input run_mode_e cur_mode
);
  run_mode_e mode_prev;

  always_ff @(posedge clk) begin
    if (rst) mode_prev <= MODE_STEP;
    else     mode_prev <= cur_mode;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !cpu_ce);

  a_r2_single_wide: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |=> !cpu_ce);

  a_r9_no_pulse_after_switch: assert property (@(posedge clk) disable iff (rst)
    (cur_mode != mode_prev) |=> !cpu_ce);

  a_r4_step_needs_press: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && $past(cur_mode) == MODE_STEP) |-> ($past(step_dn) && !$past(step_dn, 2)));
endmodule

bind run_rate_select run_rate_select_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_ce   (cpu_ce),
  .step_dn  (step_dn),
  .cur_mode (cur_mode)
);

// File: tb/run_rate_select_tb.sv
`timescale 1ns/1ps
module run_rate_select_tb;
  localparam int D = 4;
  localparam int S = 20;
  localparam int F = 5;
  localparam int LAT = 3 + D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_key_n = 1'b1, slow_key_n = 1'b1, fast_key_n = 1'b1;
  logic cpu_ce;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  run_rate_select #(.DEB_CNT(D), .SLOW_TC(S), .FAST_TC(F)) u_dut (
    .clk(clk), .rst(rst), .step_key_n(step_key_n),
    .slow_key_n(slow_key_n), .fast_key_n(fast_key_n), .cpu_ce(cpu_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample index i = rising edges since the last stimulus; only i > after counts
  task automatic watch(input int n, input int after, output int cnt,
                       output int first, output int mingap, output int maxgap);
    int last;
    cnt = 0; first = -1; mingap = 1 << 30; maxgap = -1; last = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (cpu_ce && i > after) begin
        cnt++;
        if (first < 0) first = i;
        if (last >= 0) begin
          if (i - last < mingap) mingap = i - last;
          if (i - last > maxgap) maxgap = i - last;
        end
        last = i;
      end
    end
  endtask

  initial begin
    int c, f, mn, mx;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 / R10: idle after reset
    check("R1 ce at reset release", int'(cpu_ce), 0);
    watch(60, 0, c, f, mn, mx);
    check("R10 idle pulses", c, 0);

    // R4: sweep of step presses
    for (int p = 0; p < 4; p++) begin
      step_key_n = 1'b0;
      watch(40, 0, c, f, mn, mx);
      check("R4 one pulse per press", c, 1);
      check("R4 press latency", f, LAT);
      step_key_n = 1'b1;
      watch(40, 0, c, f, mn, mx);
      check("R4 release no pulse", c, 0);
    end

    // R3: bounces shorter than D rejected, length D accepted
    for (int L = 1; L <= D; L++) begin
      step_key_n = 1'b0;
      repeat (L) @(negedge clk);
      step_key_n = 1'b1;
      watch(40, 0, c, f, mn, mx);
      check("R3 bounce filter", c, (L >= D) ? 1 : 0);
      watch(20, 0, c, f, mn, mx);
    end

    // R5: slow only
    slow_key_n = 1'b0;
    watch(LAT + 5 * S, 0, c, f, mn, mx);
    check("R5 slow count", c, 5);
    check("R5 slow first", f, LAT + S);
    check("R5 slow min gap", mn, S);
    check("R5 slow max gap", mx, S);

    // R8: step presses ignored in slow mode
    step_key_n = 1'b0;
    watch(3 * S, 0, c, f, mn, mx);
    check("R8 count with press", c, 3);
    check("R8 gap with press", mn, S);
    step_key_n = 1'b1;
    watch(3 * S, 0, c, f, mn, mx);
    check("R8 count after release", c, 3);

    // R9: slow -> turbo restart
    fast_key_n = 1'b0;
    watch(LAT + 6 * F, LAT - 1, c, f, mn, mx);
    check("R9 turbo first after switch", f, LAT + F);
    check("R6 turbo count", c, 6);
    check("R6 turbo min gap", mn, F);
    check("R6 turbo max gap", mx, F);

    // R9: turbo -> slow restart
    fast_key_n = 1'b1;
    watch(LAT + 2 * S, LAT - 1, c, f, mn, mx);
    check("R9 slow first after switch", f, LAT + S);
    check("R9 slow count after switch", c, 2);

    // R10: release all
    slow_key_n = 1'b1;
    watch(LAT + 3 * S, LAT - 1, c, f, mn, mx);
    check("R10 no pulses after release", c, 0);

    // R6: both keys together from step mode
    slow_key_n = 1'b0; fast_key_n = 1'b0;
    watch(LAT + 4 * F, 0, c, f, mn, mx);
    check("R6 turbo direct first", f, LAT + F);
    check("R6 turbo direct count", c, 4);
    slow_key_n = 1'b1;
    watch(40, LAT - 1, c, f, mn, mx);
    check("R7 turbo alone after slow release", c, 0);

    // R7: turbo alone, step still works
    watch(80, 0, c, f, mn, mx);
    check("R7 turbo alone no auto", c, 0);
    step_key_n = 1'b0;
    watch(40, 0, c, f, mn, mx);
    check("R7 step under turbo count", c, 1);
    check("R7 step under turbo latency", f, LAT);
    step_key_n = 1'b1; fast_key_n = 1'b1;
    watch(40, 0, c, f, mn, mx);

    // R1: reset in the middle of slow running
    slow_key_n = 1'b0;
    watch(LAT + S + 3, 0, c, f, mn, mx);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 ce after mid-run reset", int'(cpu_ce), 0);
    watch(LAT + S, 0, c, f, mn, mx);
    check("R1 relearn slow first", f, LAT + S);
    slow_key_n = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule